// File: doc/BRIEF.md
# Byte-Addressable Data Memory with Mapped I/O Port

This block is a synchronous data store organised as 16-bit words and addressed in bytes. A processor core uses it for loads and stores. Each access moves either a full word or a single byte. In a word, the byte at the even address sits in bits 7:0 and the byte at the odd address sits in bits 15:8. Byte reads come back right-justified and zero-extended. A byte write changes only the lane it addresses.

The two lowest byte addresses do not hold storage. They decode to an 8-bit bidirectional pin port:

- **Address 0x0000** holds the output latch. A read of this address returns the real levels on the pins.
- **Address 0x0001** holds the per-pin drive-enable mask.

A pin whose mask bit is 1 carries the latch value. A pin whose mask bit is 0 is left floating, so an outside agent can drive it.

Writes land on the rising clock edge. Read data follows the presented address combinationally, so it is valid well before the next edge. Storage words are selected by the low address bits above bit 0, and the address bits above the storage depth are not decoded.

Top module: `byte_mem_port`

## Requirements
- R1: Bytes are little-endian within a word. A byte read at an even address returns bits 7:0 of the containing word in rdata[7:0], with rdata[15:8] zero.
- R2: A write with wr_en=1 and word_sel=1 stores all 16 bits of wdata. A later word read of that address returns the same value.
- R3: A byte read (word_sel=0) at an odd address returns bits 15:8 of the containing word in rdata[7:0]. Every byte read has rdata[15:8]=0.
- R4: A byte write at an odd address stores wdata[7:0] into bits 15:8 of the word. Bits 7:0 of the word stay unchanged, and wdata[15:8] is ignored.
- R5: A byte write at an even address stores wdata[7:0] into bits 7:0 of the word. Bits 15:8 of the word stay unchanged, and wdata[15:8] is ignored.
- R6: A byte write to address 0x0001 loads the drive-enable mask. A mask bit of 1 drives the corresponding pin, and a mask bit of 0 releases it. A byte read of 0x0001 returns the mask.
- R7: Every pin whose mask bit is 1 carries the corresponding bit of the output latch. A byte write to address 0x0000 loads that latch.
- R8: A byte read of address 0x0000 returns the resolved pin levels, mixing outside-driven and inside-driven bits, zero-extended to 16 bits.
- R9: Reset (rst_n low) clears the mask and the latch, so every pin starts undriven.
- R10: A write takes effect at the rising clock edge. A read issued right after that edge returns the new value before the following edge.
- R11: A word access at an odd address acts on the containing aligned word.
- R12: A word write to address 0x0000 or 0x0001 loads the latch from wdata[7:0] and the mask from wdata[15:8]. A word read there returns {mask, pin levels}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| word_sel | input | 1 | 1 selects a 16-bit access, 0 selects an 8-bit access |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rdata | output | 16 | Read data for the presented address |
| pins | inout | 8 | Bidirectional port pins |

## Verification
The bench covers the lane-steering corners:

- **Odd-address byte read.** A design that got lane steering wrong would return the low byte, or leave the high byte in rdata[15:8].
- **Odd and even byte writes over an existing word.** A design that forgot to gate the lanes would clobber the neighbour byte. One that passed wdata[15:8] through would corrupt the upper half.
- **Odd-address word write.** A design that did not align it would land the word in the wrong place.

It also covers the port corners:

- **Mixed pin levels.** Outside agents drive some pins while the block drives others, through masks set by both byte and word writes. A read that returned the latch instead of the pins would show latch bits on outside-driven pins.
- **Floating masked-off pin.** A pin released by the mask has its latch bit set opposite to the outside level. A design that still drove that pin would show the latch value there.
- **Post-reset pin state.** Right after reset, a design that did not clear the mask would fight the outside drivers.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

    typedef enum logic [1:0] {
        ACC_WORD    = 2'd0,
        ACC_BYTE_LO = 2'd1,
        ACC_BYTE_HI = 2'd2
    } acc_kind_e;

    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;

endpackage

// File: rtl/bmp_decode.sv
module bmp_decode
    import bmp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word_sel,
    input  logic              wr_en,
    output acc_kind_e         kind,
    output logic              port_hit,
    output logic [LANES-1:0]  ram_we,
    output logic [LANES-1:0]  port_we
);

    logic [LANES-1:0] lane_en;

    always_comb begin
        unique case ({word_sel, addr[0]})
            2'b10, 2'b11: begin
                kind    = ACC_WORD;
                lane_en = 2'b11;
            end
            2'b00: begin
                kind    = ACC_BYTE_LO;
                lane_en = 2'b01;
            end
            default: begin
                kind    = ACC_BYTE_HI;
                lane_en = 2'b10;
            end
        endcase
    end

    assign port_hit = (addr[ADDR_W-1:1] == '0);
    assign ram_we   = (wr_en && !port_hit) ? lane_en : '0;
    assign port_we  = (wr_en &&  port_hit) ? lane_en : '0;

endmodule

// File: rtl/bmp_ram.sv
module bmp_ram
    import bmp_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[ln]) begin
                mem[idx] <= wword[ln*LANE_W +: LANE_W];
            end
        end

        assign rword[ln*LANE_W +: LANE_W] = mem[idx];
    end

endmodule

// File: rtl/bmp_port.sv
module bmp_port
    import bmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  we,
    input  logic [WORD_W-1:0] wword,
    inout  wire  [LANE_W-1:0] pins,
    output logic [LANE_W-1:0] pin_lvl,
    output logic [LANE_W-1:0] dir_q,
    output logic [LANE_W-1:0] out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (we[0]) out_q <= wword[LANE_W-1:0];
            if (we[1]) dir_q <= wword[WORD_W-1:LANE_W];
        end
    end

    for (genvar p = 0; p < LANE_W; p++) begin : g_pin
        assign pins[p] = dir_q[p] ? out_q[p] : 1'bz;
    end

    assign pin_lvl = pins;

endmodule

// File: rtl/byte_mem_port.sv
module byte_mem_port
    import bmp_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DEPTH_WORDS = 256,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              word_sel,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    inout  wire  [7:0]        pins
);

    acc_kind_e         kind;
    logic              port_hit;
    logic [LANES-1:0]  ram_we;
    logic [LANES-1:0]  port_we;
    logic [WORD_W-1:0] wword;
    logic [WORD_W-1:0] ram_word;
    logic [WORD_W-1:0] src_word;
    logic [LANE_W-1:0] pin_lvl;
    logic [LANE_W-1:0] dir_q;
    logic [LANE_W-1:0] out_q;

    bmp_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr     (addr),
        .word_sel (word_sel),
        .wr_en    (wr_en),
        .kind     (kind),
        .port_hit (port_hit),
        .ram_we   (ram_we),
        .port_we  (port_we)
    );

    // A byte write places its data on both lanes; the lane enables pick one.
    assign wword = (kind == ACC_WORD) ? wdata : {wdata[7:0], wdata[7:0]};

    bmp_ram #(.DEPTH(DEPTH_WORDS)) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .idx   (addr[IDX_W:1]),
        .wword (wword),
        .rword (ram_word)
    );

    bmp_port port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (port_we),
        .wword   (wword),
        .pins    (pins),
        .pin_lvl (pin_lvl),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    assign src_word = port_hit ? {dir_q, pin_lvl} : ram_word;

    always_comb begin
        unique case (kind)
            ACC_WORD:    rdata = src_word;
            ACC_BYTE_LO: rdata = {8'h00, src_word[7:0]};
            default:     rdata = {8'h00, src_word[15:8]};
        endcase
    end

endmodule

// File: rtl/bmp_chk.sv
module bmp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        wr_en,
    input logic        word_sel,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic [7:0]  pins,
    input logic [7:0]  dir_q,
    input logic [7:0]  out_q
);

    AST_WORD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_sel && addr[15:1] != '0) |=>
        (!($stable(addr) && word_sel && $past(addr) == addr) || rdata == $past(wdata))); // R2

    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> rdata[15:8] == 8'h00); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_sel && addr == 16'h0001) |=> dir_q == $past(wdata[7:0])); // R6

    AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins ^ out_q) & dir_q) == 8'h00); // R7

    AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 16'h0000 && !word_sel) |-> rdata == {8'h00, pins}); // R8

    AST_PORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_sel && addr[15:1] == '0) |=>
        (dir_q == $past(wdata[15:8]) && out_q == $past(wdata[7:0]))); // R12

endmodule

bind byte_mem_port bmp_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .word_sel (word_sel),
    .wdata    (wdata),
    .rdata    (rdata),
    .pins     (pins),
    .dir_q    (dir_q),
    .out_q    (out_q)
);

// File: tb/byte_mem_port_tb_top.sv
module byte_mem_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        word_sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    wire  [7:0]  pins;
    logic [7:0]  ext_en = '0;
    logic [7:0]  ext_val = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    for (genvar g = 0; g < 8; g++) begin : g_ext
        assign pins[g] = ext_en[g] ? ext_val[g] : 1'bz;
    end

    byte_mem_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .word_sel (word_sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .pins     (pins)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        addr = a; wdata = d; word_sel = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic w, output logic [15:0] d);
        @(negedge clk);
        addr = a; word_sel = w; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        ext_en = 8'hFF; ext_val = 8'hA5;
        rd(16'h0000, 1'b0, d);
        chk("R9 pins undriven after reset", d, 16'h00A5);
        rd(16'h0000, 1'b1, d);
        chk("R9 mask clear after reset", d, 16'h00A5);
        ext_en = 8'h00;
    endtask

    task automatic t_words();
        logic [15:0] d;
        wr(16'h0100, 16'h1234, 1'b1);
        #1 d = rdata;
        chk("R10 read right after write edge", d, 16'h1234);
        wr(16'h0122, 16'h5215, 1'b1);
        rd(16'h0100, 1'b1, d);
        chk("R2 word retained", d, 16'h1234);
        rd(16'h0122, 1'b1, d);
        chk("R2 second word", d, 16'h5215);
        rd(16'h0100, 1'b0, d);
        chk("R1 even byte read", d, 16'h0034);
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        wr(16'h0110, 16'h1234, 1'b1);
        rd(16'h0111, 1'b0, d);
        chk("R3 odd byte read", d, 16'h0012);
        wr(16'h0111, 16'hAA56, 1'b0);
        rd(16'h0110, 1'b1, d);
        chk("R4 odd byte write", d, 16'h5634);
        wr(16'h0110, 16'hFF78, 1'b0);
        rd(16'h0110, 1'b1, d);
        chk("R5 even byte write", d, 16'h5678);
    endtask

    task automatic t_odd_word();
        logic [15:0] d;
        wr(16'h0131, 16'hBEEF, 1'b1);
        rd(16'h0130, 1'b1, d);
        chk("R11 odd word write aligned", d, 16'hBEEF);
        rd(16'h0131, 1'b1, d);
        chk("R11 odd word read aligned", d, 16'hBEEF);
        rd(16'h0131, 1'b0, d);
        chk("R11 byte view of odd word", d, 16'h00BE);
    endtask

    task automatic t_port_bytes();
        logic [15:0] d;
        wr(16'h0001, 16'h0038, 1'b0);
        wr(16'h0000, 16'h002B, 1'b0);
        ext_en = 8'hC7; ext_val = 8'h85;
        #2;
        chk("R7 pins mix", {8'h00, pins}, 16'h00AD);
        chk("R6 masked-off pins follow outside", {14'h0, pins[1:0]}, 16'h0001);
        rd(16'h0000, 1'b0, d);
        chk("R8 pin level read", d, 16'h00AD);
        rd(16'h0001, 1'b0, d);
        chk("R6 mask read", d, 16'h0038);
    endtask

    task automatic t_port_word();
        logic [15:0] d;
        ext_en = 8'h07; ext_val = 8'h03;
        wr(16'h0000, 16'hF05A, 1'b1);
        ext_en = 8'h0F;
        rd(16'h0000, 1'b1, d);
        chk("R12 word write to port", d, 16'hF053);
        rd(16'h0100, 1'b1, d);
        chk("R2 storage untouched by port", d, 16'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_words();
        t_bytes();
        t_odd_word();
        t_port_bytes();
        t_port_word();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule